// File: doc/BRIEF.md
# Snapshot Channel Service Scheduler

This block decides which DMA channel is allowed to issue its next request. It does not serve channels continuously in rotation. It works in batches. When no batch is in progress, it freezes a copy of the per-channel pending vector, called the snapshot. It then walks that copy from the lowest channel index upward and grants each pending channel exactly one service. A channel whose descriptor-available bit is low when the walk reaches it is skipped for that batch. The walk does not go back for it. Pending bits that appear while a batch is running are not seen until the next snapshot is captured.

The consumer receives a one-hot grant and the matching binary index. It holds the grant while the granted channel issues its request, and it pulses the done input for one cycle when that request has been issued. Whether a channel reads or writes is not visible to the block and has no effect on the order. The channel count is a parameter; the default is 2 and it scales to 16.

Top module: `chan_snap_sched`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `gnt_o` is all zeros and `gnt_idx_o` is 0.
- R2: `gnt_o` never has more than one bit set. While it is non-zero, bit position `gnt_idx_o` of `gnt_o` is the bit that is set.
- R3: A grant, including its index, stays unchanged until `done_i` is sampled high at a rising clock edge while that grant is held.
- R4: If the batch still holds an available channel above the finished one when done is accepted, that channel's grant appears on the cycle right after the done cycle, with no idle cycle between.
- R5: Within one batch, successive grants have strictly increasing channel indices, each channel is granted at most once, and only channels present in the snapshot are granted.
- R6: A snapshot channel whose `avail_i` bit is low at the moment the walk passes it, because a higher channel is picked or nothing is left to pick, gets no grant in that batch. If no snapshot channel is available, the batch ends without a grant.
- R7: `pend_i` bits that rise while a batch is running cannot be granted before that batch ends. When the last grant of a batch completes, `gnt_o` goes to zero on the next cycle, even if more channels are pending.
- R8: While no batch is running, the pending vector is captured again every cycle. A pending bit set during that idle time produces its grant two cycles later: one cycle to capture and one to pick.
- R9: A `done_i` pulse while no grant is held has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pend_i | input | NUM_CH | Per-channel pending request level |
| avail_i | input | NUM_CH | Per-channel flag: descriptors are available in system memory |
| done_i | input | 1 | One-cycle pulse: the granted channel's request has been issued |
| gnt_o | output | NUM_CH | One-hot grant, all zeros when nothing is granted |
| gnt_idx_o | output | CH_IDX_W | Binary index of the granted channel, 0 when nothing is granted |

## Verification
The bench builds the block with NUM_CH = 4 instead of the default 2. With four channels it can form snapshots that contain gaps (such as channels 0, 1 and 3). It can also place a skipped channel between two granted ones and raise late pending bits below a channel that is still waiting in the batch, which is what tests the frozen-snapshot rule. The directed scenarios count cycles exactly at the two places where latency is specified: the back-to-back grant after done, and the two-cycle capture-and-pick path out of idle.

// File: rtl/chan_sched_pkg.sv
// Package chan_sched_pkg
// Shared types for the snapshot channel scheduler.
// Assumes: none; holds no logic.
package chan_sched_pkg;

    // Largest channel count the scheduler is sized for.
    localparam int unsigned SCHED_MAX_CH = 16;

    // Batch phase of the scheduler controller.
    typedef enum logic [1:0] {
        PH_CAPTURE = 2'd0,  // no batch running, snapshot taken every cycle
        PH_PICK    = 2'd1,  // snapshot frozen, first grant being chosen
        PH_SERVE   = 2'd2   // grant held, waiting for done
    } sched_phase_e;

endpackage

// File: rtl/sched_pick.sv
// Module sched_pick
// Finds the lowest set bit of an eligibility vector. It returns that bit
// one-hot and as an index, plus the snapshot bits strictly above it,
// which are the channels that are still to be visited in this batch.
// Assumes: purely combinational; the caller registers its outputs.
module sched_pick #(
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0]   elig_i,
    input  logic [NUM_CH-1:0]   snap_i,
    output logic [NUM_CH-1:0]   win_o,
    output logic [CH_IDX_W-1:0] win_idx_o,
    output logic [NUM_CH-1:0]   rest_o,
    output logic                any_o
);

    // below[i] is set when some eligible bit sits strictly below channel i
    logic [NUM_CH-1:0] below;

    assign below[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 1; gi < NUM_CH; gi++) begin : g_chain
            // Carry the "already found" flag up the chain.
            assign below[gi] = below[gi-1] | elig_i[gi-1];
        end
        for (gi = 0; gi < NUM_CH; gi++) begin : g_bit
            // A bit wins when it is eligible and nothing below it is.
            assign win_o[gi]  = elig_i[gi] & ~below[gi];
            // Snapshot bits above the winner stay for later visits.
            assign rest_o[gi] = snap_i[gi] & below[gi];
        end
    endgenerate

    // Encode the one-hot winner into a binary index.
    always_comb begin
        win_idx_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (win_o[i]) begin
                win_idx_o = CH_IDX_W'(i);
            end
        end
    end

    assign any_o = |elig_i;

endmodule

// File: rtl/sched_snap.sv
// Module sched_snap
// Holds the frozen snapshot of channels still to be visited in the
// current batch. The controller writes it whenever it captures or
// advances the batch.
// Assumes: the write enable and data come from one controller.
module sched_snap #(
    parameter int unsigned NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [NUM_CH-1:0] d_i,
    output logic [NUM_CH-1:0] snap_o
);

    // Snapshot storage: cleared on reset, loaded on write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_o <= '0;
        end else if (we_i) begin
            snap_o <= d_i;
        end
    end

endmodule

// File: rtl/sched_ctrl.sv
// Module sched_ctrl
// Batch controller. It captures the pending vector, picks the first
// grant, holds each grant until done, and then either moves to the next
// picked channel in the same cycle or closes the batch.
// Assumes: done_i is a one-cycle pulse; the picker outputs reflect the
// current snapshot ANDed with the availability vector.
module sched_ctrl
    import chan_sched_pkg::*;
#(
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   pend_i,
    input  logic                done_i,
    input  logic                any_i,
    input  logic [NUM_CH-1:0]   win_i,
    input  logic [CH_IDX_W-1:0] win_idx_i,
    input  logic [NUM_CH-1:0]   rest_i,
    output logic                snap_we_o,
    output logic [NUM_CH-1:0]   snap_d_o,
    output logic [NUM_CH-1:0]   gnt_o,
    output logic [CH_IDX_W-1:0] gnt_idx_o
);

    sched_phase_e        phase_q, phase_d;
    logic [NUM_CH-1:0]   gnt_d;
    logic [CH_IDX_W-1:0] idx_d;

    // Next-state logic for the phase, the grant and the snapshot write.
    always_comb begin
        phase_d   = phase_q;
        gnt_d     = gnt_o;
        idx_d     = gnt_idx_o;
        snap_we_o = 1'b0;
        snap_d_o  = '0;
        unique case (phase_q)
            PH_CAPTURE: begin
                snap_we_o = 1'b1;
                snap_d_o  = pend_i;
                if (|pend_i) begin
                    phase_d = PH_PICK;
                end
            end
            PH_PICK: begin
                snap_we_o = 1'b1;
                if (any_i) begin
                    gnt_d    = win_i;
                    idx_d    = win_idx_i;
                    snap_d_o = rest_i;
                    phase_d  = PH_SERVE;
                end else begin
                    phase_d  = PH_CAPTURE;
                end
            end
            PH_SERVE: begin
                if (done_i) begin
                    snap_we_o = 1'b1;
                    if (any_i) begin
                        gnt_d    = win_i;
                        idx_d    = win_idx_i;
                        snap_d_o = rest_i;
                    end else begin
                        gnt_d    = '0;
                        idx_d    = '0;
                        phase_d  = PH_CAPTURE;
                    end
                end
            end
            default: begin
                phase_d = PH_CAPTURE;
            end
        endcase
    end

    // State registers for the phase, the grant and its index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_CAPTURE;
            gnt_o     <= '0;
            gnt_idx_o <= '0;
        end else begin
            phase_q   <= phase_d;
            gnt_o     <= gnt_d;
            gnt_idx_o <= idx_d;
        end
    end

    // R1: reset leaves no grant behind.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (gnt_o == '0 && gnt_idx_o == '0));

    // R2: at most one channel is granted.
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R2: the index points at the granted bit.
    p_idx_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) |-> gnt_o[gnt_idx_o]);

    // R3: a grant is held until done.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && !done_i) |=> ($stable(gnt_o) && $stable(gnt_idx_o)));

    // R5: the next grant of a batch is always higher.
    p_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && done_i) |=>
            (gnt_o == '0 || gnt_idx_o > $past(gnt_idx_o)));

    // R9: done with no grant leaves the grant at zero.
    p_idle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0 && phase_q == PH_CAPTURE && done_i) |=> (gnt_o == '0));

endmodule

// File: rtl/chan_snap_sched.sv
// Module chan_snap_sched
// Top of the snapshot scheduler. It serves the pending channels in
// batches, in ascending order, one grant per channel per batch, and skips
// channels that have no descriptors available.
// Assumes: pend_i stays high until the channel is served; done_i pulses
// for one cycle per grant.
module chan_snap_sched
    import chan_sched_pkg::*;
#(
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   pend_i,
    input  logic [NUM_CH-1:0]   avail_i,
    input  logic                done_i,
    output logic [NUM_CH-1:0]   gnt_o,
    output logic [CH_IDX_W-1:0] gnt_idx_o
);

    logic [NUM_CH-1:0]   snap_q;
    logic [NUM_CH-1:0]   elig;
    logic [NUM_CH-1:0]   win;
    logic [NUM_CH-1:0]   rest;
    logic [CH_IDX_W-1:0] win_idx;
    logic                any_elig;
    logic                snap_we;
    logic [NUM_CH-1:0]   snap_d;

    // Channels that can be served now: in the snapshot and with descriptors.
    assign elig = snap_q & avail_i;

    sched_snap #(.NUM_CH(NUM_CH)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (snap_we),
        .d_i    (snap_d),
        .snap_o (snap_q)
    );

    sched_pick #(.NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_pick (
        .elig_i    (elig),
        .snap_i    (snap_q),
        .win_o     (win),
        .win_idx_o (win_idx),
        .rest_o    (rest),
        .any_o     (any_elig)
    );

    sched_ctrl #(.NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend_i),
        .done_i    (done_i),
        .any_i     (any_elig),
        .win_i     (win),
        .win_idx_i (win_idx),
        .rest_i    (rest),
        .snap_we_o (snap_we),
        .snap_d_o  (snap_d),
        .gnt_o     (gnt_o),
        .gnt_idx_o (gnt_idx_o)
    );

    // R5: a newly granted channel was in the snapshot one cycle earlier.
    p_from_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o & ~$past(gnt_o)) != '0) |-> (($past(snap_q) & gnt_o) != '0));

    // R6: a newly granted channel had descriptors available when picked.
    p_avail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o & ~$past(gnt_o)) != '0) |-> (($past(avail_i) & gnt_o) != '0));

endmodule

// File: tb/test_chan_snap_sched.sv
// Directed bench for chan_snap_sched with four channels.
module test_chan_snap_sched;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int IW         = 2;
    localparam int WATCHDOG   = 20000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pend = '0;
    logic [NCH-1:0] avail = '1;
    logic           done = 1'b0;
    logic [NCH-1:0] gnt;
    logic [IW-1:0]  gidx;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_snap_sched #(.NUM_CH(NCH), .CH_IDX_W(IW)) i_chan_snap_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend),
        .avail_i   (avail),
        .done_i    (done),
        .gnt_o     (gnt),
        .gnt_idx_o (gidx)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_grant(input int ch, input string tag);
        int exp_g = (ch < 0) ? 0 : (1 << ch);
        int exp_i = (ch < 0) ? 0 : ch;
        chk(int'(gnt) == exp_g, tag, int'(gnt), exp_g);
        chk(int'(gidx) == exp_i, tag, int'(gidx), exp_i);
    endtask

    // Wait up to 10 cycles for any grant, then check that it is channel ch.
    task automatic wait_grant(input int ch, input string tag);
        for (int k = 0; k < 10 && gnt == '0; k++) @(negedge clk);
        chk_grant(ch, tag);
    endtask

    // Check that the grant holds for two cycles, pulse done, then check the successor.
    task automatic hold_and_done(input int ch, input int nxt, input string tag);
        repeat (2) @(negedge clk);
        chk_grant(ch, "R3 hold");
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk_grant(nxt, tag);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        pend  = 4'b1111;
        repeat (3) @(negedge clk);
        chk_grant(-1, "R1 in reset");
        pend  = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk_grant(-1, "R1 after reset");
    endtask

    task automatic t_basic;
        pend = 4'b1011;
        wait_grant(0, "R5 first");
        hold_and_done(0, 1, "R4 back to back");
        hold_and_done(1, 3, "R5 gap skipped");
        pend = '0;
        hold_and_done(3, -1, "R7 batch end");
        repeat (3) @(negedge clk);
        chk_grant(-1, "R8 empty snapshot");
    endtask

    task automatic t_latency;
        pend = 4'b0100;
        @(negedge clk);
        chk_grant(-1, "R8 capture cycle");
        @(negedge clk);
        chk_grant(2, "R8 two cycle grant");
        pend = '0;
        hold_and_done(2, -1, "R7 end");
    endtask

    task automatic t_freeze;
        pend = 4'b1100;
        wait_grant(2, "R5 start high");
        pend = 4'b1111;
        hold_and_done(2, 3, "R7 late bits wait");
        hold_and_done(3, -1, "R7 gap before new batch");
        wait_grant(0, "R7 new snapshot");
        hold_and_done(0, 1, "R4 next");
        hold_and_done(1, 2, "R4 next");
        pend = '0;
        hold_and_done(2, 3, "R4 next");
        hold_and_done(3, -1, "R5 one per batch");
    endtask

    task automatic t_skip;
        pend  = 4'b1111;
        avail = 4'b1010;
        wait_grant(1, "R6 lower skipped");
        hold_and_done(1, 3, "R6 middle skipped");
        pend = '0;
        hold_and_done(3, -1, "R6 end");
        avail = 4'b0110;
        pend  = 4'b0110;
        wait_grant(1, "R6 setup");
        avail = 4'b0010;
        pend  = '0;
        hold_and_done(1, -1, "R6 lost availability");
        avail = '1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_none;
        pend  = 4'b0011;
        avail = '0;
        repeat (5) @(negedge clk);
        chk_grant(-1, "R6 nothing available");
        avail = 4'b0001;
        wait_grant(0, "R6 becomes available");
        pend = '0;
        hold_and_done(0, -1, "R6 ch1 skipped");
        avail = '1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_idle_done;
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk_grant(-1, "R9 idle done");
        pend = 4'b1000;
        @(negedge clk);
        chk_grant(-1, "R9 capture");
        @(negedge clk);
        chk_grant(3, "R9 top channel granted");
        pend = '0;
        hold_and_done(3, -1, "R9 end");
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_latency();
        t_freeze();
        t_skip();
        t_none();
        t_idle_done();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule